// File: doc/BRIEF.md
# Serial Port Register File with Receive Queue

This block is the byte-wide register file of a 16550-compatible serial port. A host reaches eight byte registers through a 3-bit offset, using one-cycle read and write strobes. The registers are:

- the divisor bytes,
- interrupt enable,
- line control,
- modem control,
- queue control,
- line status,
- modem status,
- scratch,
- interrupt identification.

Read data is registered and appears the cycle after the read strobe.

The block owns the receive queue. The queue holds one byte after reset and sixteen once software turns queuing on. Bytes reach the queue from two places: an external byte source, or the block's own transmit writes when loopback is selected. Outside loopback, a transmit write leaves through a registered one-cycle byte strobe. The block ranks its pending interrupt causes and raises one level interrupt, registered from the current state.

The modem-status bits come in from a separate block on `msr_in`, and its low nibble holds the change flags. Bit shifting, baud timing and DMA are handled elsewhere.

Top module: `serial_regbank`

## Requirements
- R1: After reset the divisor reads 12 (low byte) and 0 (high byte), interrupt enable reads 0x00, identification (offset 2) reads 0x01, line status (offset 5) reads 0x60, and irq is low.
- R2: While line control bit 7 is set, offsets 0 and 1 read and write the divisor low and high bytes instead of the data and interrupt-enable registers.
- R3: Interrupt enable (offset 1) keeps only bits 3:0, modem control (offset 4) keeps only bits 4:0, and the dropped bits read as zero. Scratch (offset 7) reads back what was written.
- R4: Identification low nibble gives the highest pending enabled cause. The causes, from highest to lowest, are:
  - overrun with enable bit 2 → 0x6;
  - receive queue non-empty with enable bit 0 → 0x4;
  - transmit-empty pending with enable bit 1 → 0x2;
  - any `msr_in[3:0]` bit set with enable bit 3 → 0x0.
  With none of these it reads 0x1.
- R5: A data write sets transmit-empty pending. A read of offset 2 that reports 0x2 clears it, so the next read reports a lower cause.
- R6: A queue-control write (offset 2) whose bit 0 differs from the current queuing state flushes the queue and sets its depth to 16 (bit 0 = 1) or 1 (bit 0 = 0). A write with bits 1:0 = 11 flushes the queue. A write with bit 0 clear and no change of state has no effect.
- R7: Identification bits 7:6 read 11 while queuing is on and 00 otherwise.
- R8: Line status always has bits 6 and 5 set. Bit 0 shows a non-empty queue and bit 1 shows overrun. Reading it clears overrun.
- R9: With modem control bit 4 set, a data write enters the receive queue and `tx_valid` stays low. Otherwise `tx_valid` pulses for one cycle with the byte on `tx_byte`, the cycle after the write.
- R10: A byte offered to a full queue that is not being read in the same cycle is dropped and sets overrun. A data read from an empty queue returns 0x00.
- R11: A data read returns and removes the queue head in arrival order. An external push in the same cycle as a data read of a full queue is accepted.
- R12: `irq` is high one cycle after any enabled cause is pending and low one cycle after none is.
- R13: An external push is stored unless a loopback data write falls in the same cycle. In that case the written byte is stored and the external byte is dropped, which sets overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read byte |
| ext_push | input | 1 | External receive byte strobe |
| ext_byte | input | 8 | External receive byte |
| msr_in | input | 8 | Modem status from the modem block (bits 3:0 are change flags) |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt |

## Verification
Two functions can meet in the same clock: a data read that pops the queue and an external push that fills it, or a loopback data write and an external push that both try to enter the queue. The bench forces each collision by raising both strobes in one cycle on a one-deep queue. It then judges the result through the read byte, the line-status data-ready and overrun bits, and the bytes drained afterwards. Interrupt ranking is provoked by making all four causes pending at once and peeling them off one read at a time.

// File: rtl/serial_regbank_pkg.sv
package serial_regbank_pkg;
  localparam logic [2:0] OFS_DATA    = 3'd0;
  localparam logic [2:0] OFS_IEN     = 3'd1;
  localparam logic [2:0] OFS_IDFC    = 3'd2;
  localparam logic [2:0] OFS_LCTL    = 3'd3;
  localparam logic [2:0] OFS_MCTL    = 3'd4;
  localparam logic [2:0] OFS_LSTAT   = 3'd5;
  localparam logic [2:0] OFS_MSTAT   = 3'd6;
  localparam logic [2:0] OFS_SCRATCH = 3'd7;

  localparam logic [3:0] CAUSE_NONE = 4'h1;
  localparam logic [3:0] CAUSE_LINE = 4'h6;
  localparam logic [3:0] CAUSE_RXD  = 4'h4;
  localparam logic [3:0] CAUSE_TXE  = 4'h2;
  localparam logic [3:0] CAUSE_MDM  = 4'h0;

  localparam int REF_CLK_HZ   = 1843200;
  localparam int RESET_BAUD   = 9600;
  localparam int DIV_RESET    = REF_CLK_HZ / RESET_BAUD / 16;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          deep,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] limit;

  assign limit = deep ? CW'(DEPTH) : CW'(1);
  assign full  = (count >= limit);
  assign empty = (count == '0);
  assign head  = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p, input logic [CW-1:0] lim);
    if ((CW'(p) + CW'(1)) >= lim) return '0;
    return p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr, limit);
      if (pop)  rd_ptr <= bump(rd_ptr, limit);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (full && !pop && !flush) |-> !push) else $error("overflow");        // R10
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    empty |-> !pop) else $error("underflow");                           // R11
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= limit) else $error("count beyond depth");                  // R6
endmodule

// File: rtl/irq_ranker.sv
module irq_ranker
  import serial_regbank_pkg::*;
(
  input  logic       line_err,
  input  logic       rx_avail,
  input  logic       txe_pend,
  input  logic       mdm_delta,
  input  logic [3:0] en,
  output logic [3:0] cause
);
  always_comb begin
    if (line_err && en[2])       cause = CAUSE_LINE;
    else if (rx_avail && en[0])  cause = CAUSE_RXD;
    else if (txe_pend && en[1])  cause = CAUSE_TXE;
    else if (mdm_delta && en[3]) cause = CAUSE_MDM;
    else                         cause = CAUSE_NONE;
  end
endmodule

// File: rtl/serial_regbank.sv
module serial_regbank
  import serial_regbank_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int QAW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  input  logic       ext_push,
  input  logic [7:0] ext_byte,
  input  logic [7:0] msr_in,
  output logic       tx_valid,
  output logic [7:0] tx_byte,
  output logic       irq
);
  logic [7:0] div_lo_q, div_hi_q, lctl_q, scr_q;
  logic [3:0] ien_q;
  logic [4:0] mctl_q;
  logic       qon_q, oe_q, txe_pend_q;

  logic       dlab, loop;
  logic       is_data_wr, is_data_rd, lb_push, pop, flush, space, ext_ok, drop;
  logic       q_push, q_full, q_empty;
  logic [7:0] q_head, q_in;
  logic [QAW:0] q_count;
  logic [3:0] cause;
  logic [7:0] iir_byte, lsr_byte;

  assign dlab       = lctl_q[7];
  assign loop       = mctl_q[4];
  assign is_data_wr = wr_en && (addr == OFS_DATA) && !dlab;
  assign is_data_rd = rd_en && (addr == OFS_DATA) && !dlab;
  assign lb_push    = is_data_wr && loop;
  assign pop        = is_data_rd && !q_empty;
  assign flush      = wr_en && (addr == OFS_IDFC) &&
                      ((wr_data[0] != qon_q) || (wr_data[0] && wr_data[1]));
  assign space      = !q_full || pop;
  assign ext_ok     = ext_push && !lb_push && space && !flush;
  assign q_push     = (lb_push && space) || ext_ok;
  assign q_in       = lb_push ? wr_data : ext_byte;
  assign drop       = (lb_push && !space) || (ext_push && !flush && (lb_push || !space));

  rxq_store #(.DEPTH(FIFO_DEPTH), .W(8)) rxq_i (
    .clk(clk), .rst(rst), .flush(flush), .deep(qon_q),
    .push(q_push), .push_data(q_in), .pop(pop),
    .head(q_head), .count(q_count), .full(q_full), .empty(q_empty)
  );

  irq_ranker rank_i (
    .line_err(oe_q), .rx_avail(!q_empty), .txe_pend(txe_pend_q),
    .mdm_delta(|msr_in[3:0]), .en(ien_q), .cause(cause)
  );

  assign iir_byte = {qon_q ? 2'b11 : 2'b00, 2'b00, cause};
  assign lsr_byte = {1'b0, 1'b1, 1'b1, 3'b000, oe_q, !q_empty};

  always_ff @(posedge clk) begin
    if (rst) begin
      div_lo_q   <= 8'(DIV_RESET);
      div_hi_q   <= 8'(DIV_RESET >> 8);
      lctl_q     <= '0;
      scr_q      <= '0;
      ien_q      <= '0;
      mctl_q     <= '0;
      qon_q      <= 1'b0;
      oe_q       <= 1'b0;
      txe_pend_q <= 1'b0;
      rd_data    <= '0;
      tx_valid   <= 1'b0;
      tx_byte    <= '0;
      irq        <= 1'b0;
    end else begin
      tx_valid <= 1'b0;
      irq      <= (cause != CAUSE_NONE);

      if (rd_en) begin
        case (addr)
          OFS_DATA:    rd_data <= dlab ? div_lo_q : (q_empty ? 8'h00 : q_head);
          OFS_IEN:     rd_data <= dlab ? div_hi_q : {4'b0, ien_q};
          OFS_IDFC:    rd_data <= iir_byte;
          OFS_LCTL:    rd_data <= lctl_q;
          OFS_MCTL:    rd_data <= {3'b0, mctl_q};
          OFS_LSTAT:   rd_data <= lsr_byte;
          OFS_MSTAT:   rd_data <= msr_in;
          default:     rd_data <= scr_q;
        endcase
      end

      if (drop) oe_q <= 1'b1;
      else if (rd_en && (addr == OFS_LSTAT)) oe_q <= 1'b0;

      if (is_data_wr) txe_pend_q <= 1'b1;
      else if (rd_en && (addr == OFS_IDFC) && (cause == CAUSE_TXE)) txe_pend_q <= 1'b0;

      if (wr_en) begin
        case (addr)
          OFS_DATA: begin
            if (dlab) div_lo_q <= wr_data;
            else if (!loop) begin
              tx_valid <= 1'b1;
              tx_byte  <= wr_data;
            end
          end
          OFS_IEN: begin
            if (dlab) div_hi_q <= wr_data;
            else      ien_q    <= wr_data[3:0];
          end
          OFS_IDFC:    qon_q  <= wr_data[0];
          OFS_LCTL:    lctl_q <= wr_data;
          OFS_MCTL:    mctl_q <= wr_data[4:0];
          OFS_SCRATCH: scr_q  <= wr_data;
          default: ;
        endcase
      end
    end
  end

  AST_IER_MASK: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_IEN && !dlab) |=> (ien_q == $past(wr_data[3:0]))) else $error("ier"); // R3
  AST_DR_FLAG: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == OFS_LSTAT) |=> (rd_data[0] == $past(!q_empty))) else $error("dr");       // R8
  AST_OE_ON_DROP: assert property (@(posedge clk) disable iff (rst)
    drop |=> oe_q) else $error("oe");                                                          // R10
  AST_TXE_ACK: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == OFS_IDFC && cause == CAUSE_TXE && !is_data_wr) |=> !txe_pend_q) else $error("txe"); // R5
  AST_LINE_FIRST: assert property (@(posedge clk) disable iff (rst)
    (oe_q && ien_q[2]) |-> (cause == CAUSE_LINE)) else $error("rank");                        // R4
  AST_IRQ_UP: assert property (@(posedge clk) disable iff (rst)
    (cause != CAUSE_NONE) |=> irq) else $error("irq up");                                      // R12
  AST_IRQ_DOWN: assert property (@(posedge clk) disable iff (rst)
    (cause == CAUSE_NONE) |=> !irq) else $error("irq down");                                   // R12
  AST_TX_PULSE: assert property (@(posedge clk) disable iff (rst)
    (is_data_wr && !loop) |=> (tx_valid && tx_byte == $past(wr_data))) else $error("tx");      // R9
endmodule

// File: tb/serial_regbank_tb_top.sv
`timescale 1ns/1ps
module serial_regbank_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0, ext_push = 1'b0;
  logic [7:0] wr_data = '0, ext_byte = '0, msr_in = '0;
  logic [7:0] rd_data, tx_byte;
  logic       tx_valid, irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  serial_regbank dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .ext_push(ext_push), .ext_byte(ext_byte),
    .msr_in(msr_in), .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] v);
    @(negedge clk); addr = a; wr_data = v; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; v = rd_data;
  endtask

  task automatic rdchk(input string tag, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic t_reset_and_divisor();
    chk("R1 irq", {7'b0, irq}, 8'h00);
    rdchk("R1 iir", 3'd2, 8'h01);
    rdchk("R1 lsr", 3'd5, 8'h60);
    rdchk("R1 ier", 3'd1, 8'h00);
    wr(3'd3, 8'h80);
    rdchk("R1 dll", 3'd0, 8'd12);
    rdchk("R1 dlh", 3'd1, 8'h00);
    wr(3'd0, 8'h34);
    wr(3'd1, 8'h56);
    rdchk("R2 dll", 3'd0, 8'h34);
    rdchk("R2 dlh", 3'd1, 8'h56);
    chk("R2 no tx", {7'b0, tx_valid}, 8'h00);
    wr(3'd3, 8'h03);
    rdchk("R2 ier", 3'd1, 8'h00);
    rdchk("R2 lcr", 3'd3, 8'h03);
  endtask

  task automatic t_masks();
    wr(3'd1, 8'hFF); rdchk("R3 ier", 3'd1, 8'h0F);
    wr(3'd1, 8'h00);
    wr(3'd4, 8'hEF); rdchk("R3 mcr", 3'd4, 8'h0F);
    wr(3'd4, 8'h00);
    wr(3'd7, 8'hA5); rdchk("R3 scr", 3'd7, 8'hA5);
  endtask

  task automatic t_transmit();
    wr(3'd0, 8'h5A);
    chk("R9 tx_valid", {7'b0, tx_valid}, 8'h01);
    chk("R9 tx_byte", tx_byte, 8'h5A);
    @(negedge clk);
    chk("R9 pulse", {7'b0, tx_valid}, 8'h00);
    rdchk("R9 no rx", 3'd5, 8'h60);
    wr(3'd1, 8'h02);
    @(negedge clk);
    chk("R12 irq up", {7'b0, irq}, 8'h01);
    rdchk("R5 iir txe", 3'd2, 8'h02);
    @(negedge clk);
    chk("R12 irq down", {7'b0, irq}, 8'h00);
    rdchk("R5 iir cleared", 3'd2, 8'h01);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_loop_single();
    wr(3'd4, 8'h10);
    wr(3'd0, 8'h41);
    chk("R9 loop no tx", {7'b0, tx_valid}, 8'h00);
    rdchk("R8 dr", 3'd5, 8'h61);
    wr(3'd0, 8'h42);
    rdchk("R10 oe", 3'd5, 8'h63);
    rdchk("R8 oe clr", 3'd5, 8'h61);
    rdchk("R11 head", 3'd0, 8'h41);
    rdchk("R10 empty rd", 3'd0, 8'h00);
  endtask

  task automatic t_queue_mode();
    wr(3'd2, 8'h01);
    rdchk("R7 iir top", 3'd2, 8'hC1);
    for (int i = 0; i < 16; i++) wr(3'd0, 8'(i * 3 + 1));
    rdchk("R6 deep no oe", 3'd5, 8'h61);
    wr(3'd0, 8'hEE);
    rdchk("R10 deep oe", 3'd5, 8'h63);
    for (int i = 0; i < 16; i++) rdchk("R11 order", 3'd0, 8'(i * 3 + 1));
    rdchk("R6 drained", 3'd5, 8'h60);
    wr(3'd0, 8'h01); wr(3'd0, 8'h02); wr(3'd0, 8'h03);
    wr(3'd2, 8'h03);
    rdchk("R6 rx reset", 3'd5, 8'h60);
    wr(3'd0, 8'h04); wr(3'd0, 8'h05);
    wr(3'd2, 8'h00);
    rdchk("R6 disable flush", 3'd5, 8'h60);
    rdchk("R7 iir off", 3'd2, 8'h01);
    wr(3'd0, 8'h11); wr(3'd0, 8'h22);
    rdchk("R6 depth one", 3'd5, 8'h63);
    rdchk("R6 depth one head", 3'd0, 8'h11);
    wr(3'd0, 8'h33);
    wr(3'd2, 8'h02);
    rdchk("R6 ignored write", 3'd5, 8'h61);
    rdchk("R6 kept byte", 3'd0, 8'h33);
  endtask

  task automatic t_priority();
    wr(3'd1, 8'h0F);
    wr(3'd0, 8'hA1);
    wr(3'd0, 8'hA2);
    msr_in = 8'h01;
    rdchk("R4 line", 3'd2, 8'h06);
    rdchk("R4 lsr", 3'd5, 8'h63);
    rdchk("R4 rxd", 3'd2, 8'h04);
    rdchk("R4 data", 3'd0, 8'hA1);
    rdchk("R4 txe", 3'd2, 8'h02);
    rdchk("R4 mdm", 3'd2, 8'h00);
    msr_in = 8'h00;
    rdchk("R4 none", 3'd2, 8'h01);
    @(negedge clk);
    chk("R12 irq idle", {7'b0, irq}, 8'h00);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_collisions();
    wr(3'd4, 8'h00);
    @(negedge clk); ext_byte = 8'h55; ext_push = 1'b1;
    @(negedge clk); ext_push = 1'b0;
    rdchk("R13 ext stored", 3'd5, 8'h61);
    @(negedge clk); addr = 3'd0; rd_en = 1'b1; ext_byte = 8'h66; ext_push = 1'b1;
    @(negedge clk); rd_en = 1'b0; ext_push = 1'b0;
    chk("R11 pop head", rd_data, 8'h55);
    rdchk("R11 push accepted", 3'd5, 8'h61);
    rdchk("R11 new head", 3'd0, 8'h66);
    wr(3'd4, 8'h10);
    @(negedge clk); addr = 3'd0; wr_data = 8'h77; wr_en = 1'b1; ext_byte = 8'h88; ext_push = 1'b1;
    @(negedge clk); wr_en = 1'b0; ext_push = 1'b0;
    chk("R9 loop tx quiet", {7'b0, tx_valid}, 8'h00);
    rdchk("R13 collide oe", 3'd5, 8'h63);
    rdchk("R13 write wins", 3'd0, 8'h77);
    rdchk("R10 empty", 3'd0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_and_divisor();
    t_masks();
    t_transmit();
    t_loop_single();
    t_queue_mode();
    t_priority();
    t_collisions();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=%h exp=%h", 8'h00, 8'h01);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule